// File: doc/BRIEF.md
# Dual-Path Channel Byte Interrupt Controller

This block sits behind a time-division channel deserializer. It watches the bytes that come off the stream. Each byte arrives with a valid strobe and is tagged with a stream number and a channel number. Two independent interrupt paths each pick one (stream, channel) pair and keep a private copy of the most recent byte from it. From that copy they decide whether to ask the processor for service.

A path works in one of two modes:

- **Static:** compares the byte against a pattern under a per-bit enable.
- **Dynamic:** looks for per-bit transitions between consecutive bytes of its channel. For each data bit, the pattern bit and the enable bit together pick the edge type.

A small register port lets the processor configure both paths and inspect them. Some reads have side effects: they release a request. An active-low interrupt line is driven while any enabled path has a request. Asserting the acknowledge input puts a vector byte on the read bus. The vector shows which paths are pending.

Top module: `chan_irq_ctrl`

## Requirements
- R12: Register map at `reg_addr`:
  - 0x0 is control and 0x1 is the vector.
  - Path 1 uses 0x2 select, 0x3 pattern, 0x4 enable mask, 0x5 image and 0x6 flags.
  - Path 2 uses the same order at 0xA to 0xE.
  - Reads return data combinationally; writes take effect at the clock edge.
- R1: A path's select register holds the stream in bits [7:5] and the channel in bits [4:0]. Only valid bytes whose tags equal that pair load the path's image register.
- R2: In static mode (control mode bit 0), a mask bit of 1 enables the compare of that bit. The path becomes pending on a selected byte when the mask is nonzero and every enabled bit equals the pattern bit. A zero mask never fires.
- R3: Control bit 0 enables path 1 onto `irq_n` and bit 1 enables path 2. `irq_n` is low exactly when an enabled path is pending.
- R4: While a path is pending, its image register ignores new bytes and keeps the byte that caused the request.
- R5: In static mode, a register read of the path's image releases the request.
- R6: Control bits 2 and 3 put path 1 and path 2 in dynamic mode. Each data bit's (pattern, mask) pair selects the edge it watches:
  - (0,0) ignores the bit.
  - (0,1) watches for a 0 to 1 change.
  - (1,0) watches for a 1 to 0 change.
  - (1,1) watches for any change.
- R7: A detected edge sets the flag bit in the same position. The path is pending while any flag is set. A register read of the flags returns them and then clears them.
- R8: After reset, the first selected byte of a path only records the previous value and raises no flag.
- R9: While `iack` is high, `reg_rdata` returns the vector:
  - bits [7:2] are writable at 0x1;
  - bit 1 shows path 2 pending;
  - bit 0 shows path 1 pending, whether or not the path is enabled.
  
  A read in that cycle has no side effect.
- R10: Writing control with bit 7 set clears both image registers, both flag registers and both pending bits in the same edge. Bit 7 reads back as 0.
- R11: Reset clears every register to 0x00 and holds `irq_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | Channel byte valid strobe |
| byte_stream | input | STREAM_W | Stream tag of the byte |
| byte_chan | input | CHAN_W | Channel tag of the byte |
| byte_data | input | DATA_W | Channel byte |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data or vector |
| iack | input | 1 | Interrupt acknowledge |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with its default widths: 8-bit data, a 3-bit stream tag and a 5-bit channel tag. The two tags together fill the select register exactly. This lets stimulus send bytes that differ from the selected pair only in the stream field or only in the channel field, which exercises each half of the tag compare. Eight data bits are enough to put rising, falling, toggle and ignored bits side by side in one byte. Static patterns can be set up in which enabled and disabled bits disagree.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] A_VEC  = 4'h1;
  // per-path offsets in reg_addr[2:0]; reg_addr[3] picks the path
  localparam logic [2:0] OFS_SEL   = 3'd2;
  localparam logic [2:0] OFS_MATCH = 3'd3;
  localparam logic [2:0] OFS_MASK  = 3'd4;
  localparam logic [2:0] OFS_IMAGE = 3'd5;
  localparam logic [2:0] OFS_FLAGS = 3'd6;
  localparam int NPATH    = 2;
  localparam int CB_EN0   = 0;   // enables at [1:0]
  localparam int CB_DYN0  = 2;   // modes at [3:2]
  localparam int CTRL_W   = 4;
endpackage

// File: rtl/chan_irq_path.sv
module chan_irq_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              dyn,
  input  logic [DATA_W-1:0] match,
  input  logic [DATA_W-1:0] mask,
  input  logic              rd_image,
  input  logic              rd_flags,
  input  logic              clr,
  output logic [DATA_W-1:0] image,
  output logic [DATA_W-1:0] flags,
  output logic              pending
);
  logic [DATA_W-1:0] img_q, img_d, flg_q, flg_d, prev_q, prev_d, det, det_v;
  logic              stat_q, stat_d, primed_q, primed_d, stat_hit;

  assign pending = dyn ? (|flg_q) : stat_q;
  assign image   = img_q;
  assign flags   = flg_q;

  // per-bit edge decode from (pattern, mask)
  always_comb begin
    det = '0;
    for (int i = 0; i < DATA_W; i++) begin
      case ({match[i], mask[i]})
        2'b01:   det[i] = ~prev_q[i] &  byte_data[i];
        2'b10:   det[i] =  prev_q[i] & ~byte_data[i];
        2'b11:   det[i] =  prev_q[i] ^  byte_data[i];
        default: det[i] = 1'b0;
      endcase
    end
  end

  assign det_v    = (hit && dyn && primed_q) ? det : '0;
  assign stat_hit = hit && !dyn && !pending && (mask != '0) &&
                    (((byte_data ^ match) & mask) == '0);

  always_comb begin
    img_d    = img_q;
    prev_d   = prev_q;
    primed_d = primed_q;
    stat_d   = stat_q;
    flg_d    = (rd_flags ? '0 : flg_q) | det_v;
    if (hit && !pending) img_d = byte_data;
    if (hit) begin
      prev_d   = byte_data;
      primed_d = 1'b1;
    end
    if (rd_image) stat_d = 1'b0;
    if (stat_hit) stat_d = 1'b1;
    if (clr) begin
      img_d  = '0;
      flg_d  = '0;
      stat_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      img_q    <= '0;
      flg_q    <= '0;
      prev_q   <= '0;
      primed_q <= 1'b0;
      stat_q   <= 1'b0;
    end else begin
      img_q    <= img_d;
      flg_q    <= flg_d;
      prev_q   <= prev_d;
      primed_q <= primed_d;
      stat_q   <= stat_d;
    end
  end
endmodule

// File: rtl/chan_irq_regs.sv
module chan_irq_regs
  import chan_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr,
  input  logic                          rd,
  input  logic                          iack,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [NPATH-1:0][DATA_W-1:0]  img,
  input  logic [NPATH-1:0][DATA_W-1:0]  flg,
  input  logic [NPATH-1:0]              pend,
  output logic [NPATH-1:0]              en,
  output logic [NPATH-1:0]              dyn,
  output logic                          clr,
  output logic [NPATH-1:0][DATA_W-1:0]  sel,
  output logic [NPATH-1:0][DATA_W-1:0]  match,
  output logic [NPATH-1:0][DATA_W-1:0]  mask,
  output logic [NPATH-1:0]              rd_img,
  output logic [NPATH-1:0]              rd_flg,
  output logic [DATA_W-1:0]             rdata
);
  localparam int VHI_W = DATA_W - NPATH;

  logic [CTRL_W-1:0]             ctrl_q, ctrl_d;
  logic [VHI_W-1:0]              vhi_q, vhi_d;
  logic [NPATH-1:0][DATA_W-1:0]  sel_q, sel_d, mat_q, mat_d, msk_q, msk_d;
  logic                          rd_ok;

  assign en    = ctrl_q[CB_EN0 +: NPATH];
  assign dyn   = ctrl_q[CB_DYN0 +: NPATH];
  assign clr   = wr && (addr == A_CTRL) && wdata[DATA_W-1];
  assign sel   = sel_q;
  assign match = mat_q;
  assign mask  = msk_q;
  assign rd_ok = rd && !iack;

  for (genvar p = 0; p < NPATH; p++) begin : g_rdfx
    assign rd_img[p] = rd_ok && (addr == {1'(p), OFS_IMAGE});
    assign rd_flg[p] = rd_ok && (addr == {1'(p), OFS_FLAGS});
  end

  always_comb begin
    ctrl_d = ctrl_q;
    vhi_d  = vhi_q;
    sel_d  = sel_q;
    mat_d  = mat_q;
    msk_d  = msk_q;
    if (wr && addr == A_CTRL) ctrl_d = wdata[CTRL_W-1:0];
    if (wr && addr == A_VEC)  vhi_d  = wdata[DATA_W-1:NPATH];
    for (int p = 0; p < NPATH; p++) begin
      if (wr && addr == {p[0], OFS_SEL})   sel_d[p] = wdata;
      if (wr && addr == {p[0], OFS_MATCH}) mat_d[p] = wdata;
      if (wr && addr == {p[0], OFS_MASK})  msk_d[p] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      vhi_q  <= '0;
      sel_q  <= '0;
      mat_q  <= '0;
      msk_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      vhi_q  <= vhi_d;
      sel_q  <= sel_d;
      mat_q  <= mat_d;
      msk_q  <= msk_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (iack || addr == A_VEC) begin
      rdata = {vhi_q, pend};
    end else if (addr == A_CTRL) begin
      rdata[CTRL_W-1:0] = ctrl_q;
    end else begin
      case (addr[2:0])
        OFS_SEL:   rdata = sel_q[addr[3]];
        OFS_MATCH: rdata = mat_q[addr[3]];
        OFS_MASK:  rdata = msk_q[addr[3]];
        OFS_IMAGE: rdata = img[addr[3]];
        OFS_FLAGS: rdata = flg[addr[3]];
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/chan_irq_ctrl.sv
module chan_irq_ctrl
  import chan_irq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int STREAM_W = 3,
  parameter int CHAN_W   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                byte_vld,
  input  logic [STREAM_W-1:0] byte_stream,
  input  logic [CHAN_W-1:0]   byte_chan,
  input  logic [DATA_W-1:0]   byte_data,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [3:0]          reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic                iack,
  output logic                irq_n
);
  localparam int TAG_W = STREAM_W + CHAN_W;

  logic [1:0]                    rst_sync_q;
  logic                          rst_core_n;
  logic [NPATH-1:0]              en, dyn, pend, hit, rd_img, rd_flg;
  logic                          clr;
  logic [NPATH-1:0][DATA_W-1:0]  sel, match, mask, img, flg;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  chan_irq_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .wr(reg_wr), .rd(reg_rd), .iack(iack),
    .addr(reg_addr), .wdata(reg_wdata), .img(img), .flg(flg), .pend(pend),
    .en(en), .dyn(dyn), .clr(clr), .sel(sel), .match(match), .mask(mask),
    .rd_img(rd_img), .rd_flg(rd_flg), .rdata(reg_rdata)
  );

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    assign hit[p] = byte_vld &&
                    (byte_stream == sel[p][CHAN_W +: STREAM_W]) &&
                    (byte_chan   == sel[p][CHAN_W-1:0]);
    chan_irq_path #(.DATA_W(DATA_W)) u_path (
      .clk(clk), .rst_n(rst_core_n), .hit(hit[p]), .byte_data(byte_data),
      .dyn(dyn[p]), .match(match[p]), .mask(mask[p]),
      .rd_image(rd_img[p]), .rd_flags(rd_flg[p]), .clr(clr),
      .image(img[p]), .flags(flg[p]), .pending(pend[p])
    );
  end

  assign irq_n = ~|(pend & en);

  if (TAG_W > DATA_W) begin : g_tag_chk
    initial $error("stream and channel tags exceed the register width");
  end
endmodule

// File: rtl/chan_irq_ctrl_chk.sv
module chan_irq_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_vld,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [3:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              iack,
  input logic              irq_n,
  input logic [1:0]        pend,
  input logic [1:0]        en,
  input logic [DATA_W-1:0] img0,
  input logic [DATA_W-1:0] flg0
);
  logic clr_wr;
  assign clr_wr = reg_wr && (reg_addr == 4'h0) && reg_wdata[DATA_W-1];

  assert_iack_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
    iack |-> (reg_rdata[1:0] == pend));

  assert_clear_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (irq_n && pend == 2'b00));

  assert_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[0] && !clr_wr) |=> $stable(img0));

  assert_flag_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !iack && reg_addr == 4'h6 && !byte_vld) |=> (flg0 == '0));

  assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en == 2'b00) |-> irq_n);
endmodule

bind chan_irq_ctrl chan_irq_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .reg_wr(reg_wr),
  .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .iack(iack), .irq_n(irq_n), .pend(pend),
  .en(en), .img0(img[0]), .flg0(flg[0])
);

// File: tb/chan_irq_ctrl_bench.sv
module chan_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       byte_vld;
  logic [2:0] byte_stream;
  logic [4:0] byte_chan;
  logic [7:0] byte_data;
  logic       reg_wr, reg_rd, iack;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  chan_irq_ctrl u_chan_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_stream(byte_stream),
    .byte_chan(byte_chan), .byte_data(byte_data), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .iack(iack), .irq_n(irq_n)
  );

  // stream[16:14] chan[13:9] data[8:1] fire[0]; path 1 selects stream 2, channel 4
  localparam logic [16:0] VEC_TBL [8] = '{
    {3'd2, 5'd4, 8'h35, 1'b0},
    {3'd1, 5'd4, 8'hA0, 1'b0},
    {3'd2, 5'd5, 8'hAF, 1'b0},
    {3'd2, 5'd4, 8'hA7, 1'b1},
    {3'd2, 5'd4, 8'h5A, 1'b0},
    {3'd2, 5'd4, 8'hAA, 1'b1},
    {3'd2, 5'd4, 8'hB0, 1'b0},
    {3'd2, 5'd4, 8'hA0, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic ack(output logic [7:0] d);
    iack = 1'b1; reg_rd = 1'b1; reg_addr = 4'h6;
    #1 d = reg_rdata;
    @(negedge clk);
    iack = 1'b0; reg_rd = 1'b0;
  endtask

  task automatic send(input logic [2:0] s, input logic [4:0] c, input logic [7:0] d);
    byte_stream = s; byte_chan = c; byte_data = d; byte_vld = 1'b1;
    @(negedge clk);
    byte_vld = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] exp_img;
    byte_vld = 0; byte_stream = 0; byte_chan = 0; byte_data = 0;
    reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0; iack = 0;
    @(negedge clk);
    do_reset();

    // R11 reset state
    check("R11 irq_n", {7'd0, irq_n}, 8'h01);
    rd(4'h0, v); check("R11 ctrl", v, 8'h00);
    rd(4'h1, v); check("R11 vector", v, 8'h00);
    rd(4'h5, v); check("R11 image1", v, 8'h00);
    rd(4'hB, v); check("R11 match2", v, 8'h00);

    // static path 1: pattern A5, compare upper nibble only
    wr(4'h2, 8'h44); wr(4'h3, 8'hA5); wr(4'h4, 8'hF0); wr(4'h0, 8'h01);
    rd(4'h2, v); check("R12 select readback", v, 8'h44);
    exp_img = 8'h00;
    for (int i = 0; i < 8; i++) begin
      logic [16:0] e;
      e = VEC_TBL[i];
      send(e[16:14], e[13:9], e[8:1]);
      if (e[16:14] == 3'd2 && e[13:9] == 5'd4) exp_img = e[8:1];
      check("R2 R3 static irq_n", {7'd0, irq_n}, {7'd0, ~e[0]});
      rd(4'h5, v); check("R1 image select", v, exp_img);
      check("R5 image read release", {7'd0, irq_n}, 8'h01);
    end

    // R4 freeze on pending
    send(3'd2, 5'd4, 8'hA1);
    send(3'd2, 5'd4, 8'hA9);
    check("R4 still pending", {7'd0, irq_n}, 8'h00);
    rd(4'h5, v); check("R4 frozen image", v, 8'hA1);
    check("R5 released", {7'd0, irq_n}, 8'h01);

    // R2 zero mask never fires
    wr(4'h4, 8'h00);
    send(3'd2, 5'd4, 8'hA5);
    check("R2 zero mask", {7'd0, irq_n}, 8'h01);

    // dynamic path 1: rising edge on bit 3
    do_reset();
    wr(4'h2, 8'h44); wr(4'h3, 8'h00); wr(4'h4, 8'h08); wr(4'h0, 8'h05);
    send(3'd2, 5'd4, 8'h08);
    check("R8 first byte primes", {7'd0, irq_n}, 8'h01);
    send(3'd2, 5'd4, 8'h00);
    check("R6 falling ignored by rising", {7'd0, irq_n}, 8'h01);
    send(3'd2, 5'd4, 8'h08);
    check("R6 rising fires", {7'd0, irq_n}, 8'h00);
    ack(v); check("R9 vector path1", v, 8'h01);
    check("R9 ack no side effect", {7'd0, irq_n}, 8'h00);
    rd(4'h5, v); check("R4 dyn image", v, 8'h08);
    rd(4'h6, v); check("R7 flags value", v, 8'h08);
    check("R7 request released", {7'd0, irq_n}, 8'h01);
    rd(4'h6, v); check("R7 flags cleared", v, 8'h00);

    // dynamic path 2: bit0 falling, bit1 toggle, others ignored
    wr(4'hA, 8'h21); wr(4'hB, 8'h03); wr(4'hC, 8'h02); wr(4'h0, 8'h0F);
    send(3'd1, 5'd1, 8'h03);
    check("R8 path2 primes", {7'd0, irq_n}, 8'h01);
    send(3'd1, 5'd1, 8'h03);
    check("R6 no change", {7'd0, irq_n}, 8'h01);
    send(3'd1, 5'd1, 8'h02);
    check("R6 falling fires", {7'd0, irq_n}, 8'h00);
    rd(4'hE, v); check("R7 falling flag", v, 8'h01);
    send(3'd1, 5'd1, 8'h00);
    rd(4'hE, v); check("R6 toggle flag", v, 8'h02);
    send(3'd1, 5'd1, 8'h01);
    check("R6 rising on falling bit ignored", {7'd0, irq_n}, 8'h01);
    send(3'd1, 5'd1, 8'hFD);
    check("R6 masked bits ignored", {7'd0, irq_n}, 8'h01);
    rd(4'hE, v); check("R6 no flags", v, 8'h00);

    // R3 disabled path pending, R9 vector upper bits
    wr(4'h0, 8'h0D);
    send(3'd1, 5'd1, 8'h00);
    check("R3 disabled path quiet", {7'd0, irq_n}, 8'h01);
    wr(4'h1, 8'hA8);
    ack(v); check("R9 vector path2 and upper", v, 8'hAA);

    // R10 clear request
    wr(4'h0, 8'h8D);
    ack(v); check("R10 vector cleared", v, 8'hA8);
    rd(4'hE, v); check("R10 flags2 cleared", v, 8'h00);
    rd(4'hD, v); check("R10 image2 cleared", v, 8'h00);
    rd(4'h5, v); check("R10 image1 cleared", v, 8'h00);
    rd(4'h0, v); check("R10 ctrl readback", v, 8'h0D);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule